// File: doc/BRIEF.md
# Doorbell-Driven Command Completion Unit

This unit is the controller side of a command ring and its event ring. Software places command descriptors in a ring in memory and then writes doorbell entry zero. The unit reads descriptors one at a time from its dequeue index. It takes a descriptor only while the descriptor's cycle bit equals the unit's consumer cycle state. Each descriptor it takes is answered with one completion event, written to the next slot of the event ring and stamped with the producer cycle state. The only command with a defined effect is the no-op, which is simply acknowledged. Any other command type is answered with an error completion code.

Each event write sets a level interrupt. The interrupt stays asserted until software clears it. Events posted while the interrupt is already pending leave it asserted and produce no new edge. Doorbell writes to any entry other than zero do nothing to this unit. Reads use a request/valid handshake, so memory may take any number of cycles to answer.

Top module: `doorbell_cmd_engine`

## Requirements
- R1: After reset `irq`, `evt_wr_en` and `cmd_rd_req` are low, the dequeue index and enqueue index are 0, and both the consumer and producer cycle states are 1.
- R2: A doorbell write with index 0 is taken at a clock edge, and `cmd_rd_req` is high, with `cmd_rd_addr` equal to the dequeue index, in the cycle after that edge. At most one read is outstanding at a time.
- R3: A descriptor is valid only when its bit 0 equals the consumer cycle state. An invalid descriptor produces no event, stops processing, and leaves the dequeue index unchanged, so the next doorbell reads the same slot again.
- R4: Valid descriptors are processed in ring order without a further doorbell. The dequeue index wraps from CMD_DEPTH-1 to 0, and the consumer cycle state inverts at that wrap.
- R5: Every valid descriptor yields exactly one event write. The event word holds the producer cycle state in bit 0, the completion code in bits 8:1, and the command's ring index in bits 8+CIDX_W:9.
- R6: The descriptor type is in bits 6:1. Type 23 is the no-op, and it completes with code 1.
- R7: Any type other than 23 completes with code 5.
- R8: Event slots are written in sequence from 0 and wrap from EVT_DEPTH-1 to 0. The producer cycle state starts at 1 and inverts at each wrap.
- R9: `irq` is high in the cycle after any event write. An event write and `irq_clr` in the same cycle leave `irq` set.
- R10: `irq` holds until `irq_clr` is asserted with no event write in that cycle, and it is low in the next cycle. Further events while `irq` is pending keep it high without a new edge.
- R11: Doorbell writes with a nonzero index cause no read and no event.
- R12: A doorbell-0 write taken while the unit is busy is remembered. When the unit next meets an invalid descriptor, it reads that slot once more before going idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr_en | input | 1 | Doorbell register write strobe |
| db_wr_idx | input | DB_IDX_W | Doorbell entry being written |
| cmd_rd_req | output | 1 | Command read request, one cycle |
| cmd_rd_addr | output | CIDX_W | Command ring index to read |
| cmd_rd_valid | input | 1 | Read data valid |
| cmd_rd_data | input | 8 | Descriptor: bit 0 cycle, bits 6:1 type |
| evt_wr_en | output | 1 | Event write strobe |
| evt_wr_addr | output | EIDX_W | Event ring slot |
| evt_wr_data | output | EVT_W | Event word |
| irq | output | 1 | Pending interrupt level |
| irq_clr | input | 1 | Interrupt clear |

## Verification
The first pattern is a single run of no-op descriptors ended by a stale cycle bit. It separates acceptance by cycle bit from acceptance by count. Mixed no-op and unknown types check the two completion codes. A longer run crosses both ring ends so that each cycle state is seen to invert. Further patterns check the interrupt in isolation: a stale slot alone, a foreign doorbell index, a clear held across an event, and a doorbell rung mid-run, which shows up as one extra read.

// File: rtl/cce_pkg.sv
package cce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_POST
    } eng_state_e;

    localparam int CMD_W  = 8;
    localparam int TYPE_W = 6;
    localparam int CODE_W = 8;

    localparam logic [TYPE_W-1:0] OP_NOOP    = 6'd23;
    localparam logic [CODE_W-1:0] CC_OK      = 8'd1;
    localparam logic [CODE_W-1:0] CC_BADTYPE = 8'd5;

endpackage

// File: rtl/cce_cmd_fetch.sv
module cce_cmd_fetch
    import cce_pkg::*;
#(
    parameter int CMD_DEPTH = 8,
    parameter int CIDX_W    = $clog2(CMD_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ring_i,
    output logic                 cmd_rd_req_o,
    output logic [CIDX_W-1:0]    cmd_rd_addr_o,
    input  logic                 cmd_rd_valid_i,
    input  logic [CMD_W-1:0]     cmd_rd_data_i,
    output logic                 post_vld_o,
    output logic [CODE_W-1:0]    post_code_o,
    output logic [CIDX_W-1:0]    post_idx_o
);

    localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(CMD_DEPTH - 1);

    typedef struct packed {
        eng_state_e          state;
        logic [CIDX_W-1:0]   deq;
        logic                ccs;
        logic                pend;
        logic [CODE_W-1:0]   code;
    } fetch_t;

    fetch_t r_q, r_d;

    always_comb begin
        r_d          = r_q;
        cmd_rd_req_o = 1'b0;
        post_vld_o   = 1'b0;
        if (ring_i && (r_q.state != ST_IDLE)) begin
            r_d.pend = 1'b1;
        end
        case (r_q.state)
            ST_IDLE: begin
                if (ring_i) begin
                    r_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                cmd_rd_req_o = 1'b1;
                r_d.state    = ST_WAIT;
            end
            ST_WAIT: begin
                if (cmd_rd_valid_i) begin
                    if (cmd_rd_data_i[0] == r_q.ccs) begin
                        r_d.code  = (cmd_rd_data_i[TYPE_W:1] == OP_NOOP) ? CC_OK : CC_BADTYPE;
                        r_d.state = ST_POST;
                    end else if (r_q.pend || ring_i) begin
                        r_d.pend  = 1'b0;
                        r_d.state = ST_FETCH;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_POST: begin
                post_vld_o = 1'b1;
                if (r_q.deq == LAST_IDX) begin
                    r_d.deq = '0;
                    r_d.ccs = ~r_q.ccs;
                end else begin
                    r_d.deq = r_q.deq + 1'b1;
                end
                r_d.state = ST_FETCH;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.deq   <= '0;
            r_q.ccs   <= 1'b1;
            r_q.pend  <= 1'b0;
            r_q.code  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_rd_addr_o = r_q.deq;
    assign post_idx_o    = r_q.deq;
    assign post_code_o   = r_q.code;

    AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd_req_o |=> !cmd_rd_req_o); // R2

    AST_IDLE_NEEDS_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !ring_i) |=> !cmd_rd_req_o); // R11

    AST_POST_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        post_vld_o |=> (cmd_rd_req_o && cmd_rd_addr_o != $past(cmd_rd_addr_o))); // R4

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        post_vld_o |-> (post_code_o == CC_OK || post_code_o == CC_BADTYPE)); // R7

endmodule

// File: rtl/cce_evt_post.sv
module cce_evt_post
    import cce_pkg::*;
#(
    parameter int EVT_DEPTH = 4,
    parameter int CIDX_W    = 3,
    parameter int EIDX_W    = $clog2(EVT_DEPTH),
    parameter int EVT_W     = 1 + CODE_W + CIDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 post_vld_i,
    input  logic [CODE_W-1:0]    post_code_i,
    input  logic [CIDX_W-1:0]    post_idx_i,
    output logic                 evt_wr_en_o,
    output logic [EIDX_W-1:0]    evt_wr_addr_o,
    output logic [EVT_W-1:0]     evt_wr_data_o
);

    localparam logic [EIDX_W-1:0] LAST_SLOT = EIDX_W'(EVT_DEPTH - 1);

    typedef struct packed {
        logic [EIDX_W-1:0] enq;
        logic              pcs;
    } prod_t;

    prod_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (post_vld_i) begin
            if (r_q.enq == LAST_SLOT) begin
                r_d.enq = '0;
                r_d.pcs = ~r_q.pcs;
            end else begin
                r_d.enq = r_q.enq + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.enq <= '0;
            r_q.pcs <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign evt_wr_en_o   = post_vld_i;
    assign evt_wr_addr_o = r_q.enq;
    assign evt_wr_data_o = {post_idx_i, post_code_i, r_q.pcs};

    AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr_en_o |=> !evt_wr_en_o); // R5

    AST_SLOT_WRAP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr_en_o && evt_wr_addr_o == LAST_SLOT) |=> (evt_wr_addr_o == '0 && r_q.pcs != $past(r_q.pcs))); // R8

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr_en_o && evt_wr_addr_o != LAST_SLOT) |=> (r_q.pcs == $past(r_q.pcs))); // R8

endmodule

// File: rtl/cce_irq_latch.sv
module cce_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (set_i) begin
            r_d.pend = 1'b1;
        end else if (clr_i) begin
            r_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o = r_q.pend;

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o); // R9

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o); // R10

    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o); // R10

endmodule

// File: rtl/doorbell_cmd_engine.sv
module doorbell_cmd_engine
    import cce_pkg::*;
#(
    parameter int CMD_DEPTH = 8,
    parameter int EVT_DEPTH = 4,
    parameter int DB_IDX_W  = 4,
    parameter int CIDX_W    = $clog2(CMD_DEPTH),
    parameter int EIDX_W    = $clog2(EVT_DEPTH),
    parameter int EVT_W     = 1 + CODE_W + CIDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                db_wr_en,
    input  logic [DB_IDX_W-1:0] db_wr_idx,
    output logic                cmd_rd_req,
    output logic [CIDX_W-1:0]   cmd_rd_addr,
    input  logic                cmd_rd_valid,
    input  logic [CMD_W-1:0]    cmd_rd_data,
    output logic                evt_wr_en,
    output logic [EIDX_W-1:0]   evt_wr_addr,
    output logic [EVT_W-1:0]    evt_wr_data,
    output logic                irq,
    input  logic                irq_clr
);

    logic                ring;
    logic                post_vld;
    logic [CODE_W-1:0]   post_code;
    logic [CIDX_W-1:0]   post_idx;

    assign ring = db_wr_en && (db_wr_idx == '0);

    cce_cmd_fetch #(
        .CMD_DEPTH (CMD_DEPTH),
        .CIDX_W    (CIDX_W)
    ) fetch_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ring_i         (ring),
        .cmd_rd_req_o   (cmd_rd_req),
        .cmd_rd_addr_o  (cmd_rd_addr),
        .cmd_rd_valid_i (cmd_rd_valid),
        .cmd_rd_data_i  (cmd_rd_data),
        .post_vld_o     (post_vld),
        .post_code_o    (post_code),
        .post_idx_o     (post_idx)
    );

    cce_evt_post #(
        .EVT_DEPTH (EVT_DEPTH),
        .CIDX_W    (CIDX_W),
        .EIDX_W    (EIDX_W),
        .EVT_W     (EVT_W)
    ) post_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .post_vld_i    (post_vld),
        .post_code_i   (post_code),
        .post_idx_i    (post_idx),
        .evt_wr_en_o   (evt_wr_en),
        .evt_wr_addr_o (evt_wr_addr),
        .evt_wr_data_o (evt_wr_data)
    );

    cce_irq_latch irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_wr_en),
        .clr_i (irq_clr),
        .irq_o (irq)
    );

    AST_EVENT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr_en |-> $past(cmd_rd_valid)); // R5

endmodule

// File: tb/doorbell_cmd_engine_tb_top.sv
`timescale 1ns/100ps
module doorbell_cmd_engine_tb_top;

    localparam int CMD_DEPTH = 8;
    localparam int EVT_DEPTH = 4;
    localparam int DB_IDX_W  = 4;
    localparam int CW        = $clog2(CMD_DEPTH);
    localparam int EW        = $clog2(EVT_DEPTH);
    localparam int EVT_W     = 9 + CW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                db_wr_en = 1'b0;
    logic [DB_IDX_W-1:0] db_wr_idx = '0;
    logic                cmd_rd_req;
    logic [CW-1:0]       cmd_rd_addr;
    logic                cmd_rd_valid = 1'b0;
    logic [7:0]          cmd_rd_data = '0;
    logic                evt_wr_en;
    logic [EW-1:0]       evt_wr_addr;
    logic [EVT_W-1:0]    evt_wr_data;
    logic                irq;
    logic                irq_clr = 1'b0;

    always #2.5 clk = ~clk;

    doorbell_cmd_engine #(
        .CMD_DEPTH (CMD_DEPTH),
        .EVT_DEPTH (EVT_DEPTH),
        .DB_IDX_W  (DB_IDX_W)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .db_wr_en     (db_wr_en),
        .db_wr_idx    (db_wr_idx),
        .cmd_rd_req   (cmd_rd_req),
        .cmd_rd_addr  (cmd_rd_addr),
        .cmd_rd_valid (cmd_rd_valid),
        .cmd_rd_data  (cmd_rd_data),
        .evt_wr_en    (evt_wr_en),
        .evt_wr_addr  (evt_wr_addr),
        .evt_wr_data  (evt_wr_data),
        .irq          (irq),
        .irq_clr      (irq_clr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_reads = 0;
    bit irq_seen = 0;
    bit done = 0;

    logic [7:0] cmem [CMD_DEPTH];
    logic [EW+EVT_W-1:0] exp_q [$];

    logic [CW-1:0] m_deq = '0;
    logic          m_ccs = 1'b1;
    logic [EW-1:0] m_enq = '0;
    logic          m_pcs = 1'b1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic [5:0] typ, input logic cyc);
        return {1'b0, typ, cyc};
    endfunction

    // driver: walk the ring model and push the events the design must produce
    task automatic expect_run();
        for (int k = 0; k < CMD_DEPTH; k++) begin
            if (cmem[m_deq][0] != m_ccs) break;
            exp_q.push_back({m_enq, m_deq, (cmem[m_deq][6:1] == 6'd23) ? 8'd1 : 8'd5, m_pcs});
            if (m_deq == CW'(CMD_DEPTH - 1)) begin m_deq = '0; m_ccs = ~m_ccs; end
            else m_deq = m_deq + 1'b1;
            if (m_enq == EW'(EVT_DEPTH - 1)) begin m_enq = '0; m_pcs = ~m_pcs; end
            else m_enq = m_enq + 1'b1;
        end
    endtask

    task automatic ring_db(input logic [DB_IDX_W-1:0] idx);
        @(negedge clk);
        db_wr_en  = 1'b1;
        db_wr_idx = idx;
        @(negedge clk);
        db_wr_en  = 1'b0;
        db_wr_idx = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // memory responder: answers a request one cycle after it was seen
    logic          pend_v = 1'b0;
    logic [CW-1:0] pend_a = '0;
    initial forever begin
        @(negedge clk);
        cmd_rd_valid = pend_v;
        cmd_rd_data  = cmem[pend_a];
        pend_v = cmd_rd_req;
        pend_a = cmd_rd_addr;
    end

    // monitor: compare each event write against the scoreboard queue
    bit prev_evt = 0;
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (prev_evt) check(irq == 1'b1, "R9 irq after event", irq, 1);
            if (irq) irq_seen = 1;
            if (cmd_rd_req) n_reads++;
            prev_evt = evt_wr_en;
            if (evt_wr_en) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected event", {evt_wr_addr, evt_wr_data}, 0);
                end else begin
                    logic [EW+EVT_W-1:0] e;
                    e = exp_q.pop_front();
                    check({evt_wr_addr, evt_wr_data} == e, "R5 R8 event slot/word",
                          {evt_wr_addr, evt_wr_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r0;
        for (int i = 0; i < CMD_DEPTH; i++) cmem[i] = mk(6'd23, 1'b0);
        idle(4);
        check(irq == 0 && evt_wr_en == 0 && cmd_rd_req == 0, "R1 reset outputs",
              {irq, evt_wr_en, cmd_rd_req}, 0);
        rst_n = 1'b1;
        idle(2);

        // R11: foreign doorbell index with a valid slot 0
        cmem[0] = mk(6'd23, 1'b1);
        ring_db(4'd3);
        idle(12);
        check(n_reads == 0, "R11 nonzero doorbell reads", n_reads, 0);
        check(irq == 0, "R11 nonzero doorbell irq", irq, 0);

        // R2 R6 R1: three no-ops, then stale slot 3
        cmem[1] = mk(6'd23, 1'b1);
        cmem[2] = mk(6'd23, 1'b1);
        cmem[3] = mk(6'd23, 1'b0);
        expect_run();
        ring_db(4'd0);
        check(cmd_rd_req == 1 && cmd_rd_addr == 0, "R2 read follows doorbell",
              {cmd_rd_req, cmd_rd_addr}, {1'b1, 3'd0});
        idle(30);
        check(exp_q.size() == 0, "R6 no-op run complete", exp_q.size(), 0);
        check(irq == 1, "R9 irq pending after run", irq, 1);

        // R10: hold then clear
        idle(5);
        check(irq == 1, "R10 irq holds", irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(irq == 0, "R10 irq clears", irq, 0);

        // R7 R8: unknown type plus wrap of the event ring
        cmem[3] = mk(6'd9, 1'b1);
        cmem[4] = mk(6'd23, 1'b1);
        cmem[5] = mk(6'd23, 1'b0);
        expect_run();
        ring_db(4'd0);
        idle(30);
        check(exp_q.size() == 0, "R7 unknown type coded", exp_q.size(), 0);
        check(irq == 1, "R10 irq kept through second event", irq, 1);

        // R4: run across the command ring end
        cmem[5] = mk(6'd23, 1'b1);
        cmem[6] = mk(6'd2, 1'b1);
        cmem[7] = mk(6'd23, 1'b1);
        cmem[0] = mk(6'd23, 1'b0);
        cmem[1] = mk(6'd23, 1'b1);
        expect_run();
        ring_db(4'd0);
        idle(40);
        check(exp_q.size() == 0, "R4 wrap run complete", exp_q.size(), 0);

        // R3: stale slot alone, then the same slot made valid
        r0 = n_reads;
        ring_db(4'd0);
        idle(12);
        check(n_reads - r0 == 1, "R3 stale slot read once", n_reads - r0, 1);
        cmem[1] = mk(6'd23, 1'b0);
        cmem[2] = mk(6'd0, 1'b1);
        expect_run();
        ring_db(4'd0);
        idle(20);
        check(exp_q.size() == 0, "R3 same slot reread", exp_q.size(), 0);

        // R9: clear held across an event, set wins
        @(negedge clk); irq_clr = 1'b1;
        idle(2);
        irq_seen = 0;
        cmem[2] = mk(6'd23, 1'b0);
        expect_run();
        ring_db(4'd0);
        idle(20);
        irq_clr = 1'b0;
        check(irq_seen == 1, "R9 set wins over clear", irq_seen, 1);
        check(irq == 0, "R9 clear after event", irq, 0);

        // R12: doorbell during processing adds one re-read
        cmem[3] = mk(6'd23, 1'b0);
        cmem[4] = mk(6'd23, 1'b0);
        expect_run();
        r0 = n_reads;
        ring_db(4'd0);
        ring_db(4'd0);
        idle(30);
        check(n_reads - r0 == 4, "R12 remembered doorbell", n_reads - r0, 4);
        check(exp_q.size() == 0, "R12 events complete", exp_q.size(), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule